// File: doc/BRIEF.md
# Format-Tagged Floating-Point Register File

This block holds 32 floating-point registers, each paired with a small tag that records how the register was last interpreted: raw, single, double, word, long, paired-single, or poisoned. A typed read of a raw register adopts the requested format. A typed read that disagrees with the stored format poisons the register. Any read of a poisoned register returns a quiet NaN shaped for the requested format.

A static mode input selects the register width. In wide mode each register is 64 bits. In narrow mode only the low 32 bits of each register are meaningful, and 64-bit formats occupy an even/odd pair. An illegal pair access in narrow mode raises a reserved-instruction flag on the port that made the access.

Reads are combinational and include the NaN substitution. Tag updates caused by reads, and all writes, commit on the rising clock edge.

Top module: `fprf_tagged`

## Requirements
- R1: After reset every register reads zero through a raw read, and every tag is raw. Format codes are: raw=0, single=1, double=2, word=3, long=4, paired=5, poisoned=7.
- R2: A typed read (any code other than raw) of a raw-tagged register returns the register contents and sets the tag to the requested format at the clock edge, so a repeat read of the same format also returns the contents.
- R3: A typed read of a register whose tag is a different concrete format returns a quiet NaN in that same read and poisons the tag. Later typed reads of any format keep returning NaNs.
- R4: The NaN patterns for a poisoned register are:
  - single: 0x000000007FBFFFFF
  - word: 0x000000007FFFFFFF
  - double: 0x7FF7FFFFFFFFFFFF
  - long: 0x7FFFFFFFFFFFFFFF
  - paired: 0x7FBFFFFF7FBFFFFF
- R5: In wide mode, single and word reads return the low 32 bits with the upper half zero. Double, long and paired reads return all 64 bits.
- R6: In wide mode, a single or word write stores 0xDEADC0DE in bits 63:32 and the value's low 32 bits in bits 31:0. The register is tagged with the written format.
- R7: In narrow mode, a double or long read at an even index n returns {reg[n+1][31:0], reg[n][31:0]}.
- R8: In narrow mode, a double or long read at an odd index raises rd_excp_o, returns zero, and poisons that register.
- R9: In narrow mode, a double or long write at even index n stores the high word in n+1 and the low word in n, and tags both registers with the format. Narrow single, word and raw writes store the low 32 bits with bits 63:32 cleared.
- R10: In narrow mode, a double or long write at an odd index n raises wr_excp_o, leaves both data words unchanged, and poisons n and n^1.
- R11: In narrow mode, a paired-single read or write raises the port's exception flag, changes no data, and poisons the addressed register. The read returns zero.
- R12: Writes take effect at the clock edge. A read in the same cycle as a write to the same register returns the old contents. When both ports update one register's tag in the same cycle, the write's tag wins.
- R13: A raw read returns the contents (all 64 bits in wide mode, the low 32 bits zero-extended in narrow mode) and never changes a tag. A raw write tags the register raw, and in wide mode stores all 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wide_i | input | 1 | 1 = 64-bit registers, 0 = 32-bit registers with pairing |
| rd_en_i | input | 1 | Read access valid (enables its tag update) |
| rd_idx_i | input | 5 | Read register index |
| rd_fmt_i | input | 3 | Requested read format code |
| rd_data_o | output | 64 | Read value (combinational) |
| rd_excp_o | output | 1 | Reserved-instruction flag for the read |
| wr_en_i | input | 1 | Write valid |
| wr_idx_i | input | 5 | Write register index |
| wr_fmt_i | input | 3 | Write format code |
| wr_data_i | input | 64 | Write value |
| wr_excp_o | output | 1 | Reserved-instruction flag for the write |

## Verification
The assertions assume that format inputs only carry the six defined access codes (never 6 or 7). They also assume that the mode input changes only between accesses, never between a write and the dependent read it is meant to affect. The directed stimulus drives only defined codes, changes wide_i at negative edges with both ports idle, and keeps read and write ports on separate registers except in the one scenario that targets same-cycle collision. The poison property is therefore only claimed for cycles without a concurrent write, since a write has tag priority.

// File: rtl/fprf_pkg.sv
package fprf_pkg;
  typedef enum logic [2:0] {
    FMT_RAW = 3'd0,
    FMT_SGL = 3'd1,
    FMT_DBL = 3'd2,
    FMT_WRD = 3'd3,
    FMT_LNG = 3'd4,
    FMT_PRS = 3'd5,
    FMT_UNK = 3'd7
  } fmt_e;

  localparam int unsigned REG_W  = 64;
  localparam int unsigned HALF_W = REG_W / 2;

  localparam logic [HALF_W-1:0] QNAN_SGL = 32'h7FBF_FFFF;
  localparam logic [HALF_W-1:0] QNAN_WRD = 32'h7FFF_FFFF;
  localparam logic [REG_W-1:0]  QNAN_DBL = 64'h7FF7_FFFF_FFFF_FFFF;
  localparam logic [REG_W-1:0]  QNAN_LNG = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [HALF_W-1:0] FILL_HI  = 32'hDEAD_C0DE;

  function automatic logic is_pair_fmt(fmt_e f);
    return (f == FMT_DBL) || (f == FMT_LNG) || (f == FMT_PRS);
  endfunction

  function automatic logic [REG_W-1:0] qnan_of(fmt_e f);
    case (f)
      FMT_SGL: return {{HALF_W{1'b0}}, QNAN_SGL};
      FMT_WRD: return {{HALF_W{1'b0}}, QNAN_WRD};
      FMT_DBL: return QNAN_DBL;
      FMT_LNG: return QNAN_LNG;
      FMT_PRS: return {QNAN_SGL, QNAN_SGL};
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/fprf_rd_path.sv
module fprf_rd_path
  import fprf_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic             wide_i,
  input  logic             rd_en_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  fmt_e             rd_fmt_i,
  input  logic [REG_W-1:0] lo_reg_i,
  input  logic [REG_W-1:0] hi_reg_i,
  input  fmt_e             tag_cur_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             rd_excp_o,
  output logic             tag_we_o,
  output fmt_e             tag_new_o
);
  logic excp;
  logic pair_req;
  fmt_e eff_tag;

  always_comb begin
    pair_req = is_pair_fmt(rd_fmt_i);
    excp     = 1'b0;
    if (!wide_i && rd_fmt_i == FMT_PRS)          excp = 1'b1;
    else if (!wide_i && pair_req && rd_idx_i[0]) excp = 1'b1;

    // tag as it stands after this access
    eff_tag = tag_cur_i;
    if (rd_fmt_i != FMT_RAW) begin
      if (tag_cur_i == FMT_RAW)       eff_tag = rd_fmt_i;
      else if (tag_cur_i != rd_fmt_i) eff_tag = FMT_UNK;
    end

    if (excp)                     rd_data_o = '0;
    else if (rd_fmt_i == FMT_RAW) rd_data_o = wide_i ? lo_reg_i : {{HALF_W{1'b0}}, lo_reg_i[HALF_W-1:0]};
    else if (eff_tag == FMT_UNK)  rd_data_o = qnan_of(rd_fmt_i);
    else if (!pair_req)           rd_data_o = {{HALF_W{1'b0}}, lo_reg_i[HALF_W-1:0]};
    else if (wide_i)              rd_data_o = lo_reg_i;
    else                          rd_data_o = {hi_reg_i[HALF_W-1:0], lo_reg_i[HALF_W-1:0]};

    rd_excp_o = rd_en_i & excp;
    tag_we_o  = rd_en_i & (rd_fmt_i != FMT_RAW);
    tag_new_o = excp ? FMT_UNK : eff_tag;
  end
endmodule

// File: rtl/fprf_wr_path.sv
module fprf_wr_path
  import fprf_pkg::*;
(
  input  logic             wide_i,
  input  logic             wr_en_i,
  input  logic             wr_odd_i,
  input  fmt_e             wr_fmt_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic             pri_we_o,
  output logic [REG_W-1:0] pri_data_o,
  output logic             pri_tag_we_o,
  output fmt_e             pri_tag_o,
  output logic             sec_we_o,
  output logic [REG_W-1:0] sec_data_o,
  output logic             sec_tag_we_o,
  output fmt_e             sec_tag_o,
  output logic             wr_excp_o
);
  logic [HALF_W-1:0] lo_w, hi_w;
  assign lo_w = wr_data_i[HALF_W-1:0];
  assign hi_w = wr_data_i[REG_W-1:HALF_W];

  always_comb begin
    pri_we_o     = 1'b0;
    pri_data_o   = '0;
    pri_tag_we_o = 1'b0;
    pri_tag_o    = FMT_UNK;
    sec_we_o     = 1'b0;
    sec_data_o   = '0;
    sec_tag_we_o = 1'b0;
    sec_tag_o    = FMT_UNK;
    wr_excp_o    = 1'b0;
    if (wr_en_i) begin
      pri_tag_we_o = 1'b1;
      case (wr_fmt_i)
        FMT_RAW: begin
          pri_we_o   = 1'b1;
          pri_data_o = wide_i ? wr_data_i : {{HALF_W{1'b0}}, lo_w};
          pri_tag_o  = FMT_RAW;
        end
        FMT_SGL, FMT_WRD: begin
          pri_we_o   = 1'b1;
          pri_data_o = {wide_i ? FILL_HI : {HALF_W{1'b0}}, lo_w};
          pri_tag_o  = wr_fmt_i;
        end
        FMT_DBL, FMT_LNG: begin
          if (wide_i) begin
            pri_we_o   = 1'b1;
            pri_data_o = wr_data_i;
            pri_tag_o  = wr_fmt_i;
          end else if (wr_odd_i) begin
            wr_excp_o    = 1'b1;
            sec_tag_we_o = 1'b1;
          end else begin
            pri_we_o     = 1'b1;
            pri_data_o   = {{HALF_W{1'b0}}, lo_w};
            pri_tag_o    = wr_fmt_i;
            sec_we_o     = 1'b1;
            sec_data_o   = {{HALF_W{1'b0}}, hi_w};
            sec_tag_we_o = 1'b1;
            sec_tag_o    = wr_fmt_i;
          end
        end
        FMT_PRS: begin
          if (wide_i) begin
            pri_we_o   = 1'b1;
            pri_data_o = wr_data_i;
            pri_tag_o  = FMT_PRS;
          end else begin
            wr_excp_o = 1'b1;
          end
        end
        default: pri_tag_o = FMT_UNK;
      endcase
    end
  end
endmodule

// File: rtl/fprf_store.sv
module fprf_store
  import fprf_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned IDX_W    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             pri_we_i,
  input  logic [REG_W-1:0] pri_data_i,
  input  logic             pri_tag_we_i,
  input  fmt_e             pri_tag_i,
  input  logic             sec_we_i,
  input  logic [REG_W-1:0] sec_data_i,
  input  logic             sec_tag_we_i,
  input  fmt_e             sec_tag_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic             rd_tag_we_i,
  input  fmt_e             rd_tag_i,
  output logic [REG_W-1:0] reg_q_o [NUM_REGS],
  output fmt_e             tag_q_o [NUM_REGS]
);
  logic [NUM_REGS-1:0] pri_hit, sec_hit, rd_hit;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
    assign pri_hit[g] = (wr_idx_i == IDX_W'(g));
    assign sec_hit[g] = ((wr_idx_i ^ IDX_W'(1)) == IDX_W'(g));
    assign rd_hit[g]  = (rd_idx_i == IDX_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        reg_q_o[i] <= '0;
        tag_q_o[i] <= FMT_RAW;
      end
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (pri_we_i && pri_hit[i])      reg_q_o[i] <= pri_data_i;
        else if (sec_we_i && sec_hit[i]) reg_q_o[i] <= sec_data_i;
        // write port owns the tag over a same-cycle read
        if (pri_tag_we_i && pri_hit[i])      tag_q_o[i] <= pri_tag_i;
        else if (sec_tag_we_i && sec_hit[i]) tag_q_o[i] <= sec_tag_i;
        else if (rd_tag_we_i && rd_hit[i])   tag_q_o[i] <= rd_tag_i;
      end
    end
  end
endmodule

// File: rtl/fprf_tagged.sv
module fprf_tagged
  import fprf_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wide_i,
  input  logic             rd_en_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [2:0]       rd_fmt_i,
  output logic [63:0]      rd_data_o,
  output logic             rd_excp_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [2:0]       wr_fmt_i,
  input  logic [63:0]      wr_data_i,
  output logic             wr_excp_o
);
  logic [REG_W-1:0] reg_q [NUM_REGS];
  fmt_e             tag_q [NUM_REGS];

  logic             pri_we, pri_tag_we, sec_we, sec_tag_we, rd_tag_we;
  logic [REG_W-1:0] pri_data, sec_data;
  fmt_e             pri_tag, sec_tag, rd_tag_new;

  fprf_rd_path #(.IDX_W(IDX_W)) i_rd_path (
    .wide_i    (wide_i),
    .rd_en_i   (rd_en_i),
    .rd_idx_i  (rd_idx_i),
    .rd_fmt_i  (fmt_e'(rd_fmt_i)),
    .lo_reg_i  (reg_q[rd_idx_i]),
    .hi_reg_i  (reg_q[rd_idx_i | IDX_W'(1)]),
    .tag_cur_i (tag_q[rd_idx_i]),
    .rd_data_o (rd_data_o),
    .rd_excp_o (rd_excp_o),
    .tag_we_o  (rd_tag_we),
    .tag_new_o (rd_tag_new)
  );

  fprf_wr_path i_wr_path (
    .wide_i       (wide_i),
    .wr_en_i      (wr_en_i),
    .wr_odd_i     (wr_idx_i[0]),
    .wr_fmt_i     (fmt_e'(wr_fmt_i)),
    .wr_data_i    (wr_data_i),
    .pri_we_o     (pri_we),
    .pri_data_o   (pri_data),
    .pri_tag_we_o (pri_tag_we),
    .pri_tag_o    (pri_tag),
    .sec_we_o     (sec_we),
    .sec_data_o   (sec_data),
    .sec_tag_we_o (sec_tag_we),
    .sec_tag_o    (sec_tag),
    .wr_excp_o    (wr_excp_o)
  );

  fprf_store #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) i_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_idx_i     (wr_idx_i),
    .pri_we_i     (pri_we),
    .pri_data_i   (pri_data),
    .pri_tag_we_i (pri_tag_we),
    .pri_tag_i    (pri_tag),
    .sec_we_i     (sec_we),
    .sec_data_i   (sec_data),
    .sec_tag_we_i (sec_tag_we),
    .sec_tag_i    (sec_tag),
    .rd_idx_i     (rd_idx_i),
    .rd_tag_we_i  (rd_tag_we),
    .rd_tag_i     (rd_tag_new),
    .reg_q_o      (reg_q),
    .tag_q_o      (tag_q)
  );
endmodule

// File: rtl/fprf_checker.sv
module fprf_checker
  import fprf_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned IDX_W    = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wide_i,
  input logic             rd_en_i,
  input logic [IDX_W-1:0] rd_idx_i,
  input logic [2:0]       rd_fmt_i,
  input logic [63:0]      rd_data_o,
  input logic             rd_excp_o,
  input logic             wr_en_i,
  input logic [IDX_W-1:0] wr_idx_i,
  input logic [2:0]       wr_fmt_i,
  input logic [REG_W-1:0] reg_q [NUM_REGS],
  input fmt_e             tag_q [NUM_REGS]
);
  p_poison_nan_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !rd_excp_o && fmt_e'(rd_fmt_i) == FMT_SGL && tag_q[rd_idx_i] == FMT_UNK)
    |-> rd_data_o == 64'h0000_0000_7FBF_FFFF);

  p_mismatch_poison_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i && fmt_e'(rd_fmt_i) != FMT_RAW && tag_q[rd_idx_i] != FMT_RAW
     && tag_q[rd_idx_i] != fmt_e'(rd_fmt_i))
    |=> tag_q[$past(rd_idx_i)] == FMT_UNK);

  p_fill_hi_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide_i && wr_en_i && (fmt_e'(wr_fmt_i) == FMT_SGL || fmt_e'(wr_fmt_i) == FMT_WRD))
    |=> reg_q[$past(wr_idx_i)][63:32] == 32'hDEAD_C0DE);

  p_odd_read_excp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wide_i && rd_en_i && rd_idx_i[0]
     && (fmt_e'(rd_fmt_i) == FMT_DBL || fmt_e'(rd_fmt_i) == FMT_LNG))
    |-> rd_excp_o && rd_data_o == '0);

  p_odd_write_poison_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wide_i && wr_en_i && wr_idx_i[0]
     && (fmt_e'(wr_fmt_i) == FMT_DBL || fmt_e'(wr_fmt_i) == FMT_LNG))
    |=> tag_q[$past(wr_idx_i)] == FMT_UNK && tag_q[$past(wr_idx_i) ^ IDX_W'(1)] == FMT_UNK
        && $stable(reg_q[$past(wr_idx_i)]));

  p_narrow_prs_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wide_i && wr_en_i && fmt_e'(wr_fmt_i) == FMT_PRS)
    |=> tag_q[$past(wr_idx_i)] == FMT_UNK);
endmodule

bind fprf_tagged fprf_checker #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) i_fprf_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wide_i    (wide_i),
  .rd_en_i   (rd_en_i),
  .rd_idx_i  (rd_idx_i),
  .rd_fmt_i  (rd_fmt_i),
  .rd_data_o (rd_data_o),
  .rd_excp_o (rd_excp_o),
  .wr_en_i   (wr_en_i),
  .wr_idx_i  (wr_idx_i),
  .wr_fmt_i  (wr_fmt_i),
  .reg_q     (reg_q),
  .tag_q     (tag_q)
);

// File: tb/test_fprf_tagged.sv
module test_fprf_tagged;
  localparam logic [2:0] F_RAW = 3'd0, F_SGL = 3'd1, F_DBL = 3'd2,
                         F_WRD = 3'd3, F_LNG = 3'd4, F_PRS = 3'd5;
  localparam logic [63:0] N_SGL = 64'h0000_0000_7FBF_FFFF;
  localparam logic [63:0] N_WRD = 64'h0000_0000_7FFF_FFFF;
  localparam logic [63:0] N_DBL = 64'h7FF7_FFFF_FFFF_FFFF;
  localparam logic [63:0] N_LNG = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] N_PRS = 64'h7FBF_FFFF_7FBF_FFFF;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wide_i = 1'b1;
  logic        rd_en_i = 1'b0;
  logic [4:0]  rd_idx_i = '0;
  logic [2:0]  rd_fmt_i = '0;
  logic [63:0] rd_data_o;
  logic        rd_excp_o;
  logic        wr_en_i = 1'b0;
  logic [4:0]  wr_idx_i = '0;
  logic [2:0]  wr_fmt_i = '0;
  logic [63:0] wr_data_i = '0;
  logic        wr_excp_o;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #4 clk_i = ~clk_i;

  fprf_tagged i_fprf_tagged (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] idx, input logic [2:0] fmt,
                    output logic [63:0] data, output logic excp);
    @(negedge clk_i);
    rd_en_i = 1'b1; rd_idx_i = idx; rd_fmt_i = fmt;
    #1;
    data = rd_data_o; excp = rd_excp_o;
    @(posedge clk_i); #1;
    rd_en_i = 1'b0;
  endtask

  task automatic wr(input logic [4:0] idx, input logic [2:0] fmt,
                    input logic [63:0] data, output logic excp);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_idx_i = idx; wr_fmt_i = fmt; wr_data_i = data;
    #1;
    excp = wr_excp_o;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic set_wide(input logic w);
    @(negedge clk_i);
    wide_i = w;
  endtask

  task automatic t_reset;
    logic [63:0] d; logic e;
    chk("R1 reset rd_excp", {63'b0, rd_excp_o}, 64'd0);
    rd(5'd5, F_RAW, d, e); chk("R1 raw read zero", d, 64'd0);
    rd(5'd3, F_SGL, d, e); chk("R1 single read zero", d, 64'd0);
    rd(5'd31, F_DBL, d, e); chk("R1 double read zero", d, 64'd0);
  endtask

  task automatic t_adopt_poison;
    logic [63:0] d; logic e;
    wr(5'd4, F_RAW, 64'h1122_3344_5566_7788, e);
    rd(5'd4, F_DBL, d, e); chk("R2 adopt double", d, 64'h1122_3344_5566_7788);
    rd(5'd4, F_DBL, d, e); chk("R2 repeat double", d, 64'h1122_3344_5566_7788);
    rd(5'd4, F_SGL, d, e); chk("R3 mismatch returns NaN", d, N_SGL);
    rd(5'd4, F_DBL, d, e); chk("R4 double NaN", d, N_DBL);
    rd(5'd4, F_LNG, d, e); chk("R4 long NaN", d, N_LNG);
    rd(5'd4, F_WRD, d, e); chk("R4 word NaN", d, N_WRD);
    rd(5'd4, F_PRS, d, e); chk("R4 paired NaN", d, N_PRS);
    rd(5'd4, F_RAW, d, e); chk("R3 contents intact", d, 64'h1122_3344_5566_7788);
  endtask

  task automatic t_wide_formats;
    logic [63:0] d; logic e;
    wr(5'd6, F_SGL, 64'hAAAA_BBBB_1234_5678, e);
    rd(5'd6, F_RAW, d, e); chk("R6 single fill", d, 64'hDEAD_C0DE_1234_5678);
    rd(5'd6, F_SGL, d, e); chk("R5 single low half", d, 64'h0000_0000_1234_5678);
    wr(5'd7, F_WRD, 64'h0102_0304_8765_4321, e);
    rd(5'd7, F_RAW, d, e); chk("R6 word fill", d, 64'hDEAD_C0DE_8765_4321);
    rd(5'd7, F_WRD, d, e); chk("R5 word low half", d, 64'h0000_0000_8765_4321);
    wr(5'd8, F_LNG, 64'hFEDC_BA98_7654_3210, e);
    rd(5'd8, F_LNG, d, e); chk("R5 long full", d, 64'hFEDC_BA98_7654_3210);
    wr(5'd9, F_PRS, 64'h3F80_0000_4000_0000, e);
    chk("R11 wide paired write no excp", {63'b0, e}, 64'd0);
    rd(5'd9, F_PRS, d, e); chk("R5 paired full", d, 64'h3F80_0000_4000_0000);
  endtask

  task automatic t_same_cycle;
    logic [63:0] d; logic e;
    wr(5'd10, F_RAW, 64'h55, e);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_idx_i = 5'd10; wr_fmt_i = F_RAW; wr_data_i = 64'h99;
    rd_en_i = 1'b1; rd_idx_i = 5'd10; rd_fmt_i = F_RAW;
    #1; chk("R12 same-cycle read old", rd_data_o, 64'h55);
    @(posedge clk_i); #1;
    wr_en_i = 1'b0; rd_en_i = 1'b0;
    rd(5'd10, F_RAW, d, e); chk("R12 write visible after edge", d, 64'h99);
    // write tag beats read tag on the same register
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_idx_i = 5'd11; wr_fmt_i = F_SGL; wr_data_i = 64'h4242;
    rd_en_i = 1'b1; rd_idx_i = 5'd11; rd_fmt_i = F_WRD;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0; rd_en_i = 1'b0;
    rd(5'd11, F_SGL, d, e); chk("R12 write tag priority", d, 64'h4242);
  endtask

  task automatic t_raw;
    logic [63:0] d; logic e;
    wr(5'd12, F_SGL, 64'h0000_0000_0BAD_BEEF, e);
    rd(5'd12, F_RAW, d, e); chk("R13 raw read", d, 64'hDEAD_C0DE_0BAD_BEEF);
    rd(5'd12, F_SGL, d, e); chk("R13 raw read keeps tag", d, 64'h0000_0000_0BAD_BEEF);
    set_wide(1'b0);
    wr(5'd13, F_RAW, 64'h7777_6666_5555_4444, e);
    rd(5'd13, F_RAW, d, e); chk("R13 narrow raw read", d, 64'h0000_0000_5555_4444);
    set_wide(1'b1);
    rd(5'd13, F_RAW, d, e); chk("R13 narrow raw write upper clear", d, 64'h0000_0000_5555_4444);
  endtask

  task automatic t_narrow_pairs;
    logic [63:0] d; logic e;
    set_wide(1'b0);
    wr(5'd14, F_DBL, 64'hCAFE_BABE_0BAD_F00D, e);
    chk("R9 even write no excp", {63'b0, e}, 64'd0);
    rd(5'd14, F_RAW, d, e); chk("R9 low word in n", d, 64'h0000_0000_0BAD_F00D);
    rd(5'd15, F_RAW, d, e); chk("R9 high word in n+1", d, 64'h0000_0000_CAFE_BABE);
    rd(5'd14, F_DBL, d, e); chk("R7 pair read", d, 64'hCAFE_BABE_0BAD_F00D);
    rd(5'd15, F_WRD, d, e); chk("R9 n+1 tagged double", d, N_WRD);
    rd(5'd17, F_LNG, d, e);
    chk("R8 odd read excp", {63'b0, e}, 64'd1);
    chk("R8 odd read data zero", d, 64'd0);
    rd(5'd17, F_SGL, d, e); chk("R8 odd read poisons", d, N_SGL);
    wr(5'd24, F_WRD, 64'h1234_5678_9ABC_DEF0, e);
    set_wide(1'b1);
    rd(5'd24, F_RAW, d, e); chk("R9 narrow word upper clear", d, 64'h0000_0000_9ABC_DEF0);
  endtask

  task automatic t_narrow_faults;
    logic [63:0] d; logic e;
    set_wide(1'b0);
    wr(5'd18, F_SGL, 64'h1, e);
    wr(5'd19, F_SGL, 64'h2, e);
    wr(5'd19, F_DBL, 64'hFFFF_FFFF_FFFF_FFFF, e);
    chk("R10 odd write excp", {63'b0, e}, 64'd1);
    rd(5'd19, F_RAW, d, e); chk("R10 n unchanged", d, 64'h2);
    rd(5'd18, F_RAW, d, e); chk("R10 n^1 unchanged", d, 64'h1);
    rd(5'd18, F_SGL, d, e); chk("R10 n^1 poisoned", d, N_SGL);
    rd(5'd19, F_SGL, d, e); chk("R10 n poisoned", d, N_SGL);
    wr(5'd20, F_PRS, 64'h1234, e);
    chk("R11 narrow paired write excp", {63'b0, e}, 64'd1);
    rd(5'd20, F_RAW, d, e); chk("R11 write leaves data", d, 64'd0);
    rd(5'd20, F_SGL, d, e); chk("R11 write poisons", d, N_SGL);
    rd(5'd22, F_PRS, d, e);
    chk("R11 narrow paired read excp", {63'b0, e}, 64'd1);
    chk("R11 paired read data zero", d, 64'd0);
    rd(5'd22, F_WRD, d, e); chk("R11 read poisons", d, N_WRD);
    set_wide(1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_adopt_poison();
    t_wide_formats();
    t_same_cycle();
    t_raw();
    t_narrow_pairs();
    t_narrow_faults();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1'b1;
      vectors++; fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule